// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a real address through a small set of block translation entries. Each entry is a pair of 32-bit words. The upper word gives the effective block base, the block length and two validity bits, one for supervisor accesses and one for user accesses. The lower word gives the real block base and a two-bit protection code. There are two banks of entries. The instruction bank serves fetches, and the data bank serves loads and stores.

Software loads the entries through a one-word-per-cycle write port. A lookup presents an address, an access type and a privilege flag. The matchers compare all entries of the selected bank in parallel. The outputs are registered and appear one clock later: a hit flag, a real address aligned down to a 4 KiB page, and a read/write/execute protection set. The block does not walk a page table and does not raise faults. The caller decides what to do with a miss or with a denied permission.

Top module: `bat_xlate`

## Requirements
- R1: The access type is encoded as 0 = load, 1 = store, 2 = fetch and 3 = reserved. A fetch searches only the instruction bank. Every other code searches only the data bank.
- R2: The upper word holds the supervisor-valid bit at bit 1 and the user-valid bit at bit 0. A supervisor access (user_i = 0) can hit an entry only if that entry's bit 1 is set. A user access (user_i = 1) can hit an entry only if that entry's bit 0 is set.
- R3: The upper word holds the block-length field at bits 12:2. That field, shifted left by 15, is cleared out of the compare mask 0xFFFE0000. This gives block sizes from 128 KiB up to 256 MiB.
- R4: An entry hits when its mask is nonzero and the effective address ANDed with the mask equals upper-word bits 31:17, with bits 16:0 taken as zero.
- R5: On a hit, the real address is (lower word AND mask) OR (effective address AND NOT mask), with bits 11:0 forced to zero.
- R6: The lower word holds the protection code at bits 1:0. The protection output is encoded {read, write, execute}. Code 0 gives 000, code 2 gives 111, and codes 1 and 3 give 101. A hit with code 0 still reports hit.
- R7: When several entries of the searched bank hit, the lowest index wins.
- R8: On a miss, the hit flag, the real address and the protection output are all zero.
- R9: Results are registered. They appear on the outputs at the first rising clock edge after the request inputs are applied.
- R10: A write selects the bank (1 = instruction, 0 = data), the index, and the word (1 = lower, 0 = upper). A write is not seen by a lookup presented in the same cycle, and is seen from the next cycle on. Reset clears every entry, so all lookups miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ea_i | input | 32 | Effective address of the lookup |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| user_i | input | 1 | 1 = user-mode access, 0 = supervisor |
| wr_en_i | input | 1 | Entry write strobe |
| wr_bank_i | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx_i | input | 2 | Entry index |
| wr_lower_i | input | 1 | 1 = lower word, 0 = upper word |
| wr_data_i | input | 32 | Write data |
| hit_o | output | 1 | Registered hit flag |
| real_addr_o | output | 32 | Registered page-aligned real address |
| prot_o | output | 3 | Registered protection {read, write, execute} |

## Verification
The bench sets up data entries that overlap. One is valid only for supervisor accesses and another is valid for both modes, so a wrong priority order or a swapped validity bit returns the wrong real base or protection. It probes addresses just inside and just outside a 2 MiB block and a 128 KiB block. A mask built from the wrong bits would either hit past the block edge or lose the offset bits inside it. The same address is presented as a fetch and as a load, so a design that ignored the access type would return the other bank's base. A write and a lookup to the same entry share one cycle, so a design that read through the write would report the new protection one cycle early.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned AW        = 32;
  localparam int unsigned EPI_LSB   = 17;
  localparam int unsigned BL_LSB    = 2;
  localparam int unsigned BL_W      = 11;
  localparam int unsigned VS_BIT    = 1;
  localparam int unsigned VU_BIT    = 0;
  localparam int unsigned PP_LSB    = 0;
  localparam int unsigned PAGE_BITS = 12;

  localparam logic [AW-1:0] EPI_MASK  = {{(AW-EPI_LSB){1'b1}}, {EPI_LSB{1'b0}}};
  localparam logic [AW-1:0] PAGE_MASK = {{(AW-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef logic [2:0] prot_t;  // {r, w, x}
  localparam prot_t PROT_NONE = 3'b000;
  localparam prot_t PROT_RX   = 3'b101;
  localparam prot_t PROT_RWX  = 3'b111;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  localparam int unsigned IDXW   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          wr_bank_i,
  input  logic [IDXW-1:0]               wr_idx_i,
  input  logic                          wr_lower_i,
  input  logic [AW-1:0]                 wr_data_i,
  input  logic                          rd_bank_i,
  output logic [NUM_ENT-1:0][AW-1:0]    upper_o,
  output logic [NUM_ENT-1:0][AW-1:0]    lower_o
);
  logic [AW-1:0] upper_q [2][NUM_ENT];
  logic [AW-1:0] lower_q [2][NUM_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < NUM_ENT; i++) begin
          upper_q[b][i] <= '0;
          lower_q[b][i] <= '0;
        end
      end
    end else if (wr_en_i) begin
      if (wr_lower_i) lower_q[wr_bank_i][wr_idx_i] <= wr_data_i;
      else            upper_q[wr_bank_i][wr_idx_i] <= wr_data_i;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      upper_o[i] = upper_q[rd_bank_i][i];
      lower_o[i] = lower_q[rd_bank_i][i];
    end
  end

  // write lands by the following edge
  logic            chk_v_q, chk_bank_q, chk_lower_q;
  logic [IDXW-1:0] chk_idx_q;
  logic [AW-1:0]   chk_data_q;
  logic [AW-1:0]   chk_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_v_q     <= 1'b0;
      chk_bank_q  <= 1'b0;
      chk_lower_q <= 1'b0;
      chk_idx_q   <= '0;
      chk_data_q  <= '0;
    end else begin
      chk_v_q     <= wr_en_i;
      chk_bank_q  <= wr_bank_i;
      chk_lower_q <= wr_lower_i;
      chk_idx_q   <= wr_idx_i;
      chk_data_q  <= wr_data_i;
    end
  end

  assign chk_rd = chk_lower_q ? lower_q[chk_bank_q][chk_idx_q]
                              : upper_q[chk_bank_q][chk_idx_q];

  a_r10_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_v_q |-> chk_rd == chk_data_q);
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_pkg::*;
(
  input  logic [AW-1:0] upper_i,
  input  logic [AW-1:0] lower_i,
  input  logic [AW-1:0] ea_i,
  input  logic          user_i,
  output logic          hit_o,
  output logic [AW-1:0] raddr_o,
  output prot_t         prot_o
);
  logic          valid;
  logic [AW-1:0] bl_ext;
  logic [AW-1:0] mask;
  logic [1:0]    pp;

  assign valid  = user_i ? upper_i[VU_BIT] : upper_i[VS_BIT];
  assign bl_ext = AW'(upper_i[BL_LSB +: BL_W]);
  assign mask   = valid ? (EPI_MASK & ~(bl_ext << EPI_LSB)) : '0;
  assign hit_o  = (|mask) && ((ea_i & mask) == (upper_i & EPI_MASK));
  assign raddr_o = ((lower_i & mask) | (ea_i & ~mask)) & PAGE_MASK;
  assign pp     = lower_i[PP_LSB +: 2];

  always_comb begin
    unique case (pp)
      2'd0:    prot_o = PROT_NONE;
      2'd2:    prot_o = PROT_RWX;
      default: prot_o = PROT_RX;
    endcase
  end
endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_ENT-1:0]         hit_i,
  input  logic [NUM_ENT-1:0][AW-1:0] raddr_i,
  input  logic [NUM_ENT-1:0][2:0]    prot_i,
  output logic                       any_o,
  output logic [AW-1:0]              raddr_o,
  output prot_t                      prot_o
);
  logic [NUM_ENT-1:0] grant;

  always_comb begin
    grant   = '0;
    raddr_o = '0;
    prot_o  = PROT_NONE;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        grant   = '0;
        grant[i] = 1'b1;
        raddr_o = raddr_i[i];
        prot_o  = prot_i[i];
      end
    end
  end

  assign any_o = |hit_i;

  a_r7_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (any_o == (grant != '0)));
  a_r7_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i[0] |-> grant[0]);
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  localparam int unsigned IDXW   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     ea_i,
  input  logic [1:0]      acc_i,
  input  logic            user_i,
  input  logic            wr_en_i,
  input  logic            wr_bank_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic            wr_lower_i,
  input  logic [31:0]     wr_data_i,
  output logic            hit_o,
  output logic [31:0]     real_addr_o,
  output logic [2:0]      prot_o
);
  logic                       fetch;
  logic [NUM_ENT-1:0][AW-1:0] upper, lower;
  logic [NUM_ENT-1:0]         ent_hit;
  logic [NUM_ENT-1:0][AW-1:0] ent_raddr;
  logic [NUM_ENT-1:0][2:0]    ent_prot;
  logic                       sel_hit;
  logic [AW-1:0]              sel_raddr;
  prot_t                      sel_prot;

  assign fetch = (acc_e'(acc_i) == ACC_FETCH);

  bat_regfile #(.NUM_ENT(NUM_ENT)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_bank_i  (wr_bank_i),
    .wr_idx_i   (wr_idx_i),
    .wr_lower_i (wr_lower_i),
    .wr_data_i  (wr_data_i),
    .rd_bank_i  (fetch),
    .upper_o    (upper),
    .lower_o    (lower)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    bat_entry_match u_match (
      .upper_i (upper[g]),
      .lower_i (lower[g]),
      .ea_i    (ea_i),
      .user_i  (user_i),
      .hit_o   (ent_hit[g]),
      .raddr_o (ent_raddr[g]),
      .prot_o  (ent_prot[g])
    );
  end

  bat_prio_sel #(.NUM_ENT(NUM_ENT)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (ent_hit),
    .raddr_i (ent_raddr),
    .prot_i  (ent_prot),
    .any_o   (sel_hit),
    .raddr_o (sel_raddr),
    .prot_o  (sel_prot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o       <= 1'b0;
      real_addr_o <= '0;
      prot_o      <= PROT_NONE;
    end else begin
      hit_o       <= sel_hit;
      real_addr_o <= sel_hit ? sel_raddr : '0;
      prot_o      <= sel_hit ? sel_prot  : PROT_NONE;
    end
  end

  a_r8_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (real_addr_o == '0) && (prot_o == PROT_NONE));
  a_r5_page_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    real_addr_o[PAGE_BITS-1:0] == '0);
  a_r6_write_implies_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_o[1] |-> prot_o[2] && prot_o[0]);
  a_r9_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (hit_o == $past(sel_hit)));
  a_r4_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 hit_o |-> real_addr_o[EPI_LSB-1:PAGE_BITS] == $past(ea_i[EPI_LSB-1:PAGE_BITS]));
endmodule

// File: tb/bat_xlate_tb.sv
`timescale 1ns/1ps
module bat_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ea = '0;
  logic [1:0]  acc = '0;
  logic        user = 1'b0;
  logic        wr_en = 1'b0, wr_bank = 1'b0, wr_lower = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        hit;
  logic [31:0] raddr;
  logic [2:0]  prot;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bat_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ea_i(ea), .acc_i(acc), .user_i(user),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_idx_i(wr_idx),
    .wr_lower_i(wr_lower), .wr_data_i(wr_data),
    .hit_o(hit), .real_addr_o(raddr), .prot_o(prot)
  );

  // {acc[2], user, ea[32], hit, addr[32], prot[3]}
  localparam int NV = 14;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'h1000_1234, 1'b1, 32'h8000_1000, 3'b111}, // R4 R5 R6 sup load, entry 0
    {2'd1, 1'b1, 32'h1000_5678, 1'b1, 32'h9000_5000, 3'b101}, // R2 R7 user skips entry 0
    {2'd0, 1'b0, 32'h2001_2345, 1'b1, 32'h4001_2000, 3'b101}, // R1 load uses data bank
    {2'd2, 1'b0, 32'h2001_2345, 1'b1, 32'h6001_2000, 3'b111}, // R1 fetch uses instr bank
    {2'd0, 1'b1, 32'h2001_2345, 1'b1, 32'h4001_2000, 3'b101}, // R2 user-valid entry
    {2'd2, 1'b0, 32'h1000_1234, 1'b0, 32'h0000_0000, 3'b000}, // R1 R8 fetch misses
    {2'd0, 1'b0, 32'h3000_0010, 1'b1, 32'h5000_0000, 3'b000}, // R6 code 0 hit, no rights
    {2'd0, 1'b1, 32'h3000_0010, 1'b0, 32'h0000_0000, 3'b000}, // R2 R8 user-invalid
    {2'd0, 1'b0, 32'h1002_0000, 1'b0, 32'h0000_0000, 3'b000}, // R3 past 128K block
    {2'd0, 1'b0, 32'h2020_0000, 1'b0, 32'h0000_0000, 3'b000}, // R3 past 2M block
    {2'd0, 1'b0, 32'h201F_FFFF, 1'b1, 32'h401F_F000, 3'b101}, // R3 R5 top of 2M block
    {2'd0, 1'b0, 32'h201A_BCDE, 1'b1, 32'h401A_B000, 3'b101}, // R5 offset bits kept
    {2'd3, 1'b0, 32'h1000_1234, 1'b1, 32'h8000_1000, 3'b111}, // R1 reserved -> data bank
    {2'd1, 1'b0, 32'h1000_1234, 1'b1, 32'h8000_1000, 3'b111}  // R7 sup store, entry 0 first
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual hit/addr/prot=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bank, input logic [1:0] idx, input logic lower,
                    input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_bank = bank; wr_idx = idx; wr_lower = lower; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [1:0] a, input logic u,
                      input logic [31:0] e, input logic [35:0] exp);
    @(negedge clk);
    acc = a; user = u; ea = e;
    @(negedge clk);
    chk(req, {hit, raddr, prot}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset outputs", {hit, raddr, prot}, 36'h0);
    rst_n = 1'b1;
    look("R10 reset clears entries", 2'd0, 1'b0, 32'h0000_0000, 36'h0);
    look("R10 reset clears entries", 2'd2, 1'b1, 32'h1000_0000, 36'h0);

    wr(1'b0, 2'd0, 1'b0, 32'h1000_0002); wr(1'b0, 2'd0, 1'b1, 32'h8000_0002);
    wr(1'b0, 2'd1, 1'b0, 32'h2000_003F); wr(1'b0, 2'd1, 1'b1, 32'h4000_0001);
    wr(1'b0, 2'd2, 1'b0, 32'h1000_0003); wr(1'b0, 2'd2, 1'b1, 32'h9000_0003);
    wr(1'b0, 2'd3, 1'b0, 32'h3000_0002); wr(1'b0, 2'd3, 1'b1, 32'h5000_0000);
    wr(1'b1, 2'd0, 1'b0, 32'h2000_0003); wr(1'b1, 2'd0, 1'b1, 32'h6000_0002);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vector %0d", i);
      look(tag, VEC[i][70:69], VEC[i][68], VEC[i][67:36], VEC[i][35:0]);
    end

    // R10: write and lookup in same cycle -> old value, then new value
    @(negedge clk);
    wr_en = 1'b1; wr_bank = 1'b0; wr_idx = 2'd3; wr_lower = 1'b1; wr_data = 32'h5000_0002;
    acc = 2'd0; user = 1'b0; ea = 32'h3000_0010;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 write not seen same cycle", {hit, raddr, prot}, {1'b1, 32'h5000_0000, 3'b000});
    @(negedge clk);
    chk("R10 write seen next cycle", {hit, raddr, prot}, {1'b1, 32'h5000_0000, 3'b111});

    // R9: output follows the edge after the input change
    @(negedge clk);
    ea = 32'h1000_1234;
    @(posedge clk); #1;
    chk("R9 one-cycle latency", {hit, raddr, prot}, {1'b1, 32'h8000_1000, 3'b111});

    // R1: data bank write does not disturb fetch path
    wr(1'b0, 2'd0, 1'b1, 32'h7000_0002);
    look("R1 fetch bank untouched", 2'd2, 1'b0, 32'h2001_2345, {1'b1, 32'h6001_2000, 3'b111});
    look("R10 data bank rewritten", 2'd0, 1'b0, 32'h1000_1234, {1'b1, 32'h7000_1000, 3'b111});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule